// File: doc/BRIEF.md
# I2C Master FIFO and Watermark Interrupt Unit

This block sits between software and the bus engine of an I2C master. It keeps one byte queue for transmit and one for receive. Software pushes outgoing bytes into the transmit queue and the bus engine pops them. The bus engine pushes incoming bytes into the receive queue and software pops them. Every port is one byte wide.

Two programmable 4-bit watermarks watch the queue levels. When enabled, the receive watermark asks software to drain a nearly full receive queue, and the transmit watermark asks software to refill a nearly drained transmit queue. This lets a long message go through queues that are shorter than the message. The bus engine also signals the end of a transfer. That event is held in a sticky flag. The flag and the enabled watermark conditions share one pending bit and one interrupt line, which a global enable gates. Writing the flush register empties both queues at once. Software does this before each message, and may then preload up to 12 bytes before starting the transfer.

Top module: `i2cm_fifo_irq`

## Requirements
- R1: After reset both queue levels are 0, `irq` is 0 and `stat` reads 5'b01000.
- R2: Bytes written on `tx_wr` leave on `tx_rdata` in write order, and each `tx_pop` advances the queue by one byte. When the transmit queue is empty, `tx_rdata` reads 0 and a pop is ignored.
- R3: A write to a transmit queue that already holds DEPTH (16) bytes is ignored. The level stays at 16 and the stored bytes are unchanged.
- R4: Bytes pushed by the bus engine on `rx_push` are read by software on `rx_rdata` in arrival order. Data is valid in the cycle `rx_rd` is high, and the read removes the byte. A read of an empty receive queue returns 0 and leaves the level at 0.
- R5: The receive watermark is `cfg_wdata[19:16]` and its enable is `cfg_wdata[10]`. While the enable is set, the pending bit is 1 whenever the receive level is greater than or equal to the watermark.
- R6: The transmit watermark is `cfg_wdata[15:12]` and its enable is `cfg_wdata[9]`. While the enable is set, the pending bit is 1 whenever the transmit level is less than or equal to the watermark.
- R7: A `done_evt` pulse sets a sticky flag that keeps the pending bit at 1 until `done_ack`. If both arrive in the same cycle, the set wins. `irq` equals the pending bit ANDed with the global enable `cfg_wdata[1]`. Clearing the global enable drops `irq` but leaves `stat[2]` unchanged.
- R8: A `flush_we` with `flush_wdata[0]`=1 empties both queues in one cycle. The flush wins over any push or pop in the same cycle. With `flush_wdata[0]`=0 the write has no effect.
- R9: `stat[4]` is 1 when the transmit queue is full. `stat[3]` is 1 when the receive queue is empty. `stat[2]` is the pending bit. `stat[1:0]` read 0.
- R10: A push into a full receive queue is ignored, and the receive level never exceeds 16.
- R11: A `cfg_we` write takes effect from the next clock edge. `irq` reflects the new configuration one cycle after the write.

Top module ports follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Control register write strobe |
| cfg_wdata | input | 32 | Control value (watermarks, enables) |
| flush_we | input | 1 | Flush register write strobe |
| flush_wdata | input | 32 | Flush value, bit 0 flushes |
| tx_wr | input | 1 | Software pushes a transmit byte |
| tx_wdata | input | 8 | Transmit byte from software |
| tx_pop | input | 1 | Bus engine consumes a transmit byte |
| tx_rdata | output | 8 | Oldest transmit byte, 0 when empty |
| rx_push | input | 1 | Bus engine stores a received byte |
| rx_pdata | input | 8 | Received byte from bus engine |
| rx_rd | input | 1 | Software reads a receive byte |
| rx_rdata | output | 8 | Oldest receive byte, 0 when empty |
| done_evt | input | 1 | Transfer-complete pulse |
| done_ack | input | 1 | Clears the sticky completion flag |
| tx_level | output | 5 | Transmit queue occupancy |
| rx_level | output | 5 | Receive queue occupancy |
| stat | output | 5 | Status: [4] tx full, [3] rx empty, [2] pending |
| irq | output | 1 | Interrupt line |

## Verification
The assertions assume that the bus engine never asserts `rx_push` after a flush without a matching bus event. They also assume that `done_evt` and `done_ack` are single-cycle strobes, and that every input changes away from the rising clock edge. The stimulus drives every strobe on the falling edge and holds it for exactly one cycle. The bench pushes past full and reads past empty on purpose, and it issues a flush together with pushes and pops, so the overflow and priority properties are exercised.

// File: rtl/i2cm_fifo_pkg.sv
package i2cm_fifo_pkg;
    localparam int BYTE_W   = 8;
    localparam int LVL_W    = 4;
    localparam int REG_W    = 32;
    // control bit positions decoded by software
    localparam int RXLVL_LSB = 16;
    localparam int TXLVL_LSB = 12;
    localparam int RXIE_BIT  = 10;
    localparam int TXIE_BIT  = 9;
    localparam int GIE_BIT   = 1;
    localparam int FLUSH_BIT = 0;

    typedef struct packed {
        logic [LVL_W-1:0] rx_lvl;
        logic [LVL_W-1:0] tx_lvl;
        logic             rx_ie;
        logic             tx_ie;
        logic             gie;
    } irq_cfg_t;

    function automatic irq_cfg_t decode_cfg(input logic [REG_W-1:0] w);
        irq_cfg_t c;
        c.rx_lvl = w[RXLVL_LSB +: LVL_W];
        c.tx_lvl = w[TXLVL_LSB +: LVL_W];
        c.rx_ie  = w[RXIE_BIT];
        c.tx_ie  = w[TXIE_BIT];
        c.gie    = w[GIE_BIT];
        return c;
    endfunction
endpackage

// File: rtl/i2cm_byte_fifo.sv
module i2cm_byte_fifo #(
    parameter int DEPTH = 16,
    parameter int W     = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             flush,
    input  logic             push,
    input  logic [W-1:0]     pdata,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [CNT_W-1:0] count,
    output logic             full,
    output logic             empty
);
    logic [W-1:0]     mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             push_ok, pop_ok;

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CNT_W'(DEPTH));
    assign empty   = (count == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign head    = empty ? '0 : mem[rd_ptr];

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) wr_ptr <= bump(wr_ptr);
            if (pop_ok)  rd_ptr <= bump(rd_ptr);
            count <= count + CNT_W'(push_ok) - CNT_W'(pop_ok);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst && !flush && push_ok) mem[wr_ptr] <= pdata;
    end
endmodule

// File: rtl/i2cm_irq_merge.sv
module i2cm_irq_merge
    import i2cm_fifo_pkg::*;
#(
    parameter int CNT_W = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  irq_cfg_t         cfg,
    input  logic [CNT_W-1:0] tx_count,
    input  logic [CNT_W-1:0] rx_count,
    input  logic             done_set,
    input  logic             done_clr,
    output logic             pending,
    output logic             irq
);
    logic done_flag;
    logic rx_hit, tx_hit;

    always_ff @(posedge clk) begin
        if (rst)           done_flag <= 1'b0;
        else if (done_set) done_flag <= 1'b1;
        else if (done_clr) done_flag <= 1'b0;
    end

    assign rx_hit  = cfg.rx_ie && (rx_count >= CNT_W'(cfg.rx_lvl));
    assign tx_hit  = cfg.tx_ie && (tx_count <= CNT_W'(cfg.tx_lvl));
    assign pending = done_flag || rx_hit || tx_hit;
    assign irq     = cfg.gie && pending;
endmodule

// File: rtl/i2cm_fifo_irq.sv
module i2cm_fifo_irq
    import i2cm_fifo_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_we,
    input  logic [REG_W-1:0]  cfg_wdata,
    input  logic              flush_we,
    input  logic [REG_W-1:0]  flush_wdata,
    input  logic              tx_wr,
    input  logic [BYTE_W-1:0] tx_wdata,
    input  logic              tx_pop,
    output logic [BYTE_W-1:0] tx_rdata,
    input  logic              rx_push,
    input  logic [BYTE_W-1:0] rx_pdata,
    input  logic              rx_rd,
    output logic [BYTE_W-1:0] rx_rdata,
    input  logic              done_evt,
    input  logic              done_ack,
    output logic [CNT_W-1:0]  tx_level,
    output logic [CNT_W-1:0]  rx_level,
    output logic [4:0]        stat,
    output logic              irq
);
    irq_cfg_t cfg_q;
    logic     flush;
    logic     tx_full, tx_empty, rx_full, rx_empty, pending;

    assign flush = flush_we && flush_wdata[FLUSH_BIT];

    always_ff @(posedge clk) begin
        if (rst)         cfg_q <= '0;
        else if (cfg_we) cfg_q <= decode_cfg(cfg_wdata);
    end

    i2cm_byte_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_txq (
        .clk(clk), .rst(rst), .flush(flush),
        .push(tx_wr), .pdata(tx_wdata), .pop(tx_pop),
        .head(tx_rdata), .count(tx_level), .full(tx_full), .empty(tx_empty)
    );

    i2cm_byte_fifo #(.DEPTH(DEPTH), .W(BYTE_W)) u_rxq (
        .clk(clk), .rst(rst), .flush(flush),
        .push(rx_push), .pdata(rx_pdata), .pop(rx_rd),
        .head(rx_rdata), .count(rx_level), .full(rx_full), .empty(rx_empty)
    );

    i2cm_irq_merge #(.CNT_W(CNT_W)) u_irq (
        .clk(clk), .rst(rst), .cfg(cfg_q),
        .tx_count(tx_level), .rx_count(rx_level),
        .done_set(done_evt), .done_clr(done_ack),
        .pending(pending), .irq(irq)
    );

    assign stat = {tx_full, rx_empty, pending, 2'b00};
endmodule

// File: rtl/i2cm_fifo_irq_chk.sv
module i2cm_fifo_irq_chk #(
    parameter int DEPTH = 16,
    localparam int CNT_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst,
    input logic             flush_we,
    input logic [31:0]      flush_wdata,
    input logic             tx_wr,
    input logic             tx_pop,
    input logic             rx_rd,
    input logic [7:0]       rx_rdata,
    input logic             done_evt,
    input logic             done_ack,
    input logic [CNT_W-1:0] tx_level,
    input logic [CNT_W-1:0] rx_level,
    input logic [4:0]       stat,
    input logic             irq
);
    a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (tx_level == CNT_W'(DEPTH) && tx_wr && !tx_pop && !flush_we)
        |=> tx_level == CNT_W'(DEPTH));

    a_r8_flush_empties: assert property (@(posedge clk) disable iff (rst)
        (flush_we && flush_wdata[0]) |=> (tx_level == '0 && rx_level == '0));

    a_r4_empty_reads_zero: assert property (@(posedge clk) disable iff (rst)
        (rx_level == '0) |-> (rx_rdata == 8'h00));

    a_r7_done_sticky: assert property (@(posedge clk) disable iff (rst)
        done_evt |=> stat[2]);

    a_r7_irq_needs_pending: assert property (@(posedge clk) disable iff (rst)
        irq |-> stat[2]);

    a_r10_rx_bounded: assert property (@(posedge clk) disable iff (rst)
        rx_level <= CNT_W'(DEPTH));

    a_r9_rx_empty_flag: assert property (@(posedge clk) disable iff (rst)
        stat[3] == (rx_level == '0));
endmodule

bind i2cm_fifo_irq i2cm_fifo_irq_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst(rst), .flush_we(flush_we), .flush_wdata(flush_wdata),
    .tx_wr(tx_wr), .tx_pop(tx_pop), .rx_rd(rx_rd), .rx_rdata(rx_rdata),
    .done_evt(done_evt), .done_ack(done_ack), .tx_level(tx_level),
    .rx_level(rx_level), .stat(stat), .irq(irq)
);

// File: tb/sim_i2cm_fifo_irq.sv
`timescale 1ns/1ps
module sim_i2cm_fifo_irq;
    logic        clk = 0, rst = 1;
    logic        cfg_we = 0, flush_we = 0, tx_wr = 0, tx_pop = 0;
    logic        rx_push = 0, rx_rd = 0, done_evt = 0, done_ack = 0;
    logic [31:0] cfg_wdata = 0, flush_wdata = 0;
    logic [7:0]  tx_wdata = 0, rx_pdata = 0;
    logic [7:0]  tx_rdata, rx_rdata;
    logic [4:0]  tx_level, rx_level, stat;
    logic        irq;
    int          n_run = 0, n_fail = 0;

    always #4 clk = ~clk;

    i2cm_fifo_irq u0 (.*);

    task automatic check(string req, int act, int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(); @(negedge clk); endtask

    task automatic write_cfg(logic [31:0] v);
        cfg_we = 1; cfg_wdata = v; tick(); cfg_we = 0;
    endtask

    task automatic do_flush(logic [31:0] v);
        flush_we = 1; flush_wdata = v; tick(); flush_we = 0; flush_wdata = 0;
    endtask

    task automatic tx_put(logic [7:0] b);
        tx_wr = 1; tx_wdata = b; tick(); tx_wr = 0;
    endtask

    task automatic tx_take(); tx_pop = 1; tick(); tx_pop = 0; endtask

    task automatic rx_put(logic [7:0] b);
        rx_push = 1; rx_pdata = b; tick(); rx_push = 0;
    endtask

    task automatic rx_get(output logic [7:0] b);
        rx_rd = 1; #1 b = rx_rdata; tick(); rx_rd = 0;
    endtask

    task automatic t_reset();
        check("R1 tx_level", tx_level, 0);
        check("R1 rx_level", rx_level, 0);
        check("R1 irq", irq, 0);
        check("R1 stat", stat, 5'b01000);
    endtask

    task automatic t_tx_order();
        tx_put(8'hA1); tx_put(8'hB2); tx_put(8'hC3);
        check("R2 level", tx_level, 3);
        check("R2 head0", tx_rdata, 8'hA1);
        tx_take();
        check("R2 head1", tx_rdata, 8'hB2);
        tx_take(); tx_take();
        check("R2 drained", tx_level, 0);
        check("R2 empty data", tx_rdata, 0);
        tx_take();
        check("R2 empty pop", tx_level, 0);
    endtask

    task automatic t_tx_overflow();
        do_flush(1);
        for (int i = 0; i < 16; i++) tx_put(8'(8'h10 + i));
        check("R3 full level", tx_level, 16);
        check("R9 tx full bit", stat[4], 1);
        tx_put(8'hEE);
        check("R3 level held", tx_level, 16);
        for (int i = 0; i < 16; i++) begin
            check("R3 content", tx_rdata, 8'h10 + i);
            tx_take();
        end
        check("R3 drained", tx_level, 0);
    endtask

    task automatic t_rx_path();
        logic [7:0] b;
        do_flush(1);
        rx_put(8'h5A); rx_put(8'h6B); rx_put(8'h7C);
        check("R4 level", rx_level, 3);
        check("R9 rx not empty", stat[3], 0);
        rx_get(b); check("R4 byte0", b, 8'h5A);
        rx_get(b); check("R4 byte1", b, 8'h6B);
        rx_get(b); check("R4 byte2", b, 8'h7C);
        rx_get(b); check("R4 empty read", b, 0);
        check("R4 empty level", rx_level, 0);
        for (int i = 0; i < 17; i++) rx_put(8'(i));
        check("R10 rx capped", rx_level, 16);
        rx_get(b); check("R10 oldest kept", b, 0);
        do_flush(1);
    endtask

    task automatic t_rx_watermark();
        do_flush(1);
        write_cfg((32'd4 << 16) | (32'd1 << 10) | 32'd2);
        rx_put(1); rx_put(2); rx_put(3);
        check("R5 below mark", irq, 0);
        rx_put(4);
        check("R5 at mark irq", irq, 1);
        check("R5 pending", stat[2], 1);
        begin logic [7:0] b; rx_get(b); end
        check("R5 drained below", irq, 0);
        do_flush(1);
    endtask

    task automatic t_tx_watermark();
        do_flush(1);
        cfg_we = 1; cfg_wdata = (32'd2 << 12) | (32'd1 << 9) | 32'd2;
        #1 check("R11 not yet", irq, 0);
        tick(); cfg_we = 0;
        check("R6 empty irq", irq, 1);
        tx_put(1); tx_put(2); tx_put(3);
        check("R6 above mark", irq, 0);
        tx_take();
        check("R6 at mark", irq, 1);
        write_cfg(32'd2);
        check("R6 masked", irq, 0);
        do_flush(1);
    endtask

    task automatic t_done();
        write_cfg(32'd2);
        check("R7 idle", irq, 0);
        done_evt = 1; tick(); done_evt = 0;
        check("R7 set irq", irq, 1);
        tick(); tick(); tick();
        check("R7 sticky", stat[2], 1);
        write_cfg(32'd0);
        check("R7 gie off irq", irq, 0);
        check("R7 gie off stat", stat[2], 1);
        done_evt = 1; done_ack = 1; tick(); done_evt = 0; done_ack = 0;
        check("R7 set wins", stat[2], 1);
        done_ack = 1; tick(); done_ack = 0;
        check("R7 cleared", stat[2], 0);
    endtask

    task automatic t_flush();
        for (int i = 0; i < 5; i++) begin tx_put(8'(i)); rx_put(8'(i)); end
        do_flush(32'h0000_0002);
        check("R8 no-op tx", tx_level, 5);
        check("R8 no-op rx", rx_level, 5);
        flush_we = 1; flush_wdata = 1;
        tx_wr = 1; tx_pop = 1; rx_push = 1; rx_rd = 1;
        tick();
        flush_we = 0; flush_wdata = 0; tx_wr = 0; tx_pop = 0; rx_push = 0; rx_rd = 0;
        check("R8 tx flushed", tx_level, 0);
        check("R8 rx flushed", rx_level, 0);
        check("R8 stat", stat, 5'b01000);
    endtask

    initial begin
        fork
            begin
                tick(); tick(); rst = 0; tick();
                t_reset();
                t_tx_order();
                t_tx_overflow();
                t_rx_path();
                t_rx_watermark();
                t_tx_watermark();
                t_done();
                t_flush();
            end
            begin
                repeat (200000) @(posedge clk);
                n_fail++;
                $display("FAIL watchdog: actual hung expected done");
            end
        join_any
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule